// File: doc/BRIEF.md
# Two-wire register target with commit-busy flag

This block is the serial control port of a digitally set resistor. It listens to a two-wire bus (SCL and SDA, both sampled through a synchroniser on a faster system clock) and pulls SDA low through an open-drain enable when it acknowledges or sends a zero. A small register file holds the settings. A host can write one register per transaction, or read any number of registers in sequence. The register address steps forward after each byte the block sends.

The target answers only to a select byte whose upper five bits are a fixed pattern and whose next two bits match two strap inputs. Every accepted write starts a modelled storage commit, but only once the closing STOP arrives. While the commit runs, bit 5 of a read-only status register reads as 1 and further data bytes are refused. The host polls that bit before it trusts a read-back. The commit length is a cycle-count parameter.

There is no streaming interface at the block edge. The bus pins and straps are plain signals, and the bus protocol sets all flow control: the host ACK or NACK after each byte sent is the only back-pressure.

Top module: `dcr_i2c_target`

## Requirements
- R1: The select byte, sent MSB first, is accepted only if bits 7..3 equal 01010 and bits 2..1 equal `strap_i[1:0]`. Bit 0 is R/W (0 = write, 1 = read). Any other select byte gets no ACK, and SDA stays released until the next START.
- R2: A write is START, select with R/W=0, register address byte, one data byte, STOP. The target ACKs all three bytes. A data byte sent to address 0..NREGS-1 is stored there and reads back unchanged.
- R3: The busy flag rises only on the STOP that follows an accepted data byte. A repeated START after the data byte does not start the commit.
- R4: Once set, the busy flag stays set for COMMIT_CYCLES clock cycles and then clears. No new commit starts while it is set.
- R5: The status register at address STAT_ADDR reads 0x20 (bit 5 set) while busy and 0x00 otherwise. Writes to it have no effect.
- R6: A read is START, select with R/W=0, address byte, repeated START, select with R/W=1. The target ACKs all three bytes, then sends data MSB first. It changes its SDA drive only while SCL is low.
- R7: After each byte sent, the register address increments by one. An address that is neither in the file nor the status register reads 0x00.
- R8: A master ACK after a sent byte causes the next byte to be sent. A master NACK ends the read: the target releases SDA and stays silent until the next START.
- R9: A data byte that arrives while the busy flag is set is NACKed. It leaves the register unchanged and starts no commit.
- R10: A START or STOP at any bit position drops the partial byte and resets the bit counter. The next full transaction is then handled normally.
- R11: After reset, SDA is released, all registers read 0x00 and the busy flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap_i | input | 2 | Address strap bits compared with select bits 2..1 |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
The hardest state to reach is a status read taken after a data byte has been accepted but before its STOP. The stimulus gets there with a chain of repeated STARTs. The write is followed directly by a new addressing phase and a read of the status register, so the bench can show the flag is still clear, and then that it rises at the STOP. A second hard case is a write that lands inside the commit window. The bench times it by counting clock cycles from the STOP it issued, and confirms the NACK and the unchanged register by reading back later.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_DEV,
    S_DEV_ACK,
    S_ADDR,
    S_ADDR_ACK,
    S_WDATA,
    S_WDATA_ACK,
    S_RDATA,
    S_RACK,
    S_IGNORE
  } tgt_state_t;

  localparam logic [4:0] SEL_PREFIX = 5'b01010;
  localparam logic [3:0] BYTE_BITS  = 4'd8;
endpackage

// File: rtl/dcr_bus_sync.sv
module dcr_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_q     = scl_pipe[STAGES-1];
  assign sda_q     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;
  assign start_det = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/dcr_regfile.sv
module dcr_regfile #(
  parameter int          NREGS         = 4,
  parameter logic [7:0]  STAT_ADDR     = 8'h08,
  parameter int          COMMIT_CYCLES = 5_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [7:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       commit_start,
  output logic       busy
);
  localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1;
  localparam int CW    = $clog2(COMMIT_CYCLES + 1);

  logic [7:0]    regs [NREGS];
  logic [CW-1:0] commit_cnt;

  genvar g;
  generate
    for (g = 0; g < NREGS; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs[g] <= '0;
        else if (wr_en && wr_addr == 8'(g)) regs[g] <= wr_data;
      end
    end
  endgenerate

  always_comb begin
    if (rd_addr < 8'(NREGS))       rd_data = regs[rd_addr[IDX_W-1:0]];
    else if (rd_addr == STAT_ADDR) rd_data = {2'b00, busy, 5'b00000};
    else                           rd_data = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                commit_cnt <= '0;
    else if (commit_start)     commit_cnt <= CW'(COMMIT_CYCLES);
    else if (commit_cnt != '0) commit_cnt <= commit_cnt - CW'(1);
  end

  assign busy = (commit_cnt != '0);

  // Storage never changes while a commit is running.
  assert_no_write_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !busy);
  // A commit is never restarted on top of a running one.
  assert_commit_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_start |-> !busy);
  // The flag only comes up right after a commit request.
  assert_busy_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(commit_start));
endmodule

// File: rtl/dcr_i2c_engine.sv
module dcr_i2c_engine
  import dcr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_q,
  input  logic       sda_q,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [1:0] strap,
  input  logic       busy,
  input  logic [7:0] rd_data,
  output logic [7:0] rd_addr,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       commit_start,
  output logic       sda_oe
);
  tgt_state_t state;
  logic [3:0] bitcnt;
  logic [7:0] shreg, txreg, addr;
  logic       rw, mack, wr_pending;

  assign rd_addr = addr;
  assign wr_addr = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      bitcnt       <= '0;
      shreg        <= '0;
      txreg        <= '0;
      addr         <= '0;
      rw           <= 1'b0;
      mack         <= 1'b0;
      wr_pending   <= 1'b0;
      sda_oe       <= 1'b0;
      wr_en        <= 1'b0;
      wr_data      <= '0;
      commit_start <= 1'b0;
    end else begin
      wr_en        <= 1'b0;
      commit_start <= 1'b0;
      if (start_det) begin
        state  <= S_DEV;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= S_IDLE;
        bitcnt <= '0;
        sda_oe <= 1'b0;
        if (wr_pending) begin
          commit_start <= 1'b1;
          wr_pending   <= 1'b0;
        end
      end else if (scl_rise) begin
        case (state)
          S_DEV, S_ADDR, S_WDATA: begin
            shreg  <= {shreg[6:0], sda_q};
            bitcnt <= bitcnt + 4'd1;
          end
          S_RDATA: bitcnt <= bitcnt + 4'd1;
          S_RACK:  mack   <= ~sda_q;
          default: ;
        endcase
      end else if (scl_fall) begin
        case (state)
          S_DEV: if (bitcnt == BYTE_BITS) begin
            if (shreg[7:3] == SEL_PREFIX && shreg[2:1] == strap) begin
              rw     <= shreg[0];
              sda_oe <= 1'b1;
              state  <= S_DEV_ACK;
            end else begin
              state <= S_IGNORE;
            end
          end
          S_ADDR: if (bitcnt == BYTE_BITS) begin
            addr   <= shreg;
            sda_oe <= 1'b1;
            state  <= S_ADDR_ACK;
          end
          S_WDATA: if (bitcnt == BYTE_BITS) begin
            state <= S_WDATA_ACK;
            if (!busy) begin
              sda_oe     <= 1'b1;
              wr_en      <= 1'b1;
              wr_data    <= shreg;
              wr_pending <= 1'b1;
            end
          end
          S_DEV_ACK: begin
            bitcnt <= '0;
            if (rw) begin
              state  <= S_RDATA;
              txreg  <= rd_data;
              sda_oe <= ~rd_data[7];
            end else begin
              state  <= S_ADDR;
              sda_oe <= 1'b0;
            end
          end
          S_ADDR_ACK: begin
            bitcnt <= '0;
            sda_oe <= 1'b0;
            state  <= S_WDATA;
          end
          S_WDATA_ACK: begin
            sda_oe <= 1'b0;
            state  <= S_IGNORE;
          end
          S_RDATA: begin
            if (bitcnt == BYTE_BITS) begin
              sda_oe <= 1'b0;
              addr   <= addr + 8'd1;
              state  <= S_RACK;
            end else begin
              txreg  <= {txreg[6:0], 1'b0};
              sda_oe <= ~txreg[6];
            end
          end
          S_RACK: begin
            if (mack) begin
              state  <= S_RDATA;
              bitcnt <= '0;
              txreg  <= rd_data;
              sda_oe <= ~rd_data[7];
            end else begin
              state <= S_IGNORE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // The target only starts pulling SDA while SCL is low.
  assert_oe_scl_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_q);
  // Idle or ignoring means hands off the data line.
  assert_quiet_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE || state == S_IGNORE) |-> !sda_oe);
  // A START always restarts byte framing from bit zero.
  assert_start_reframe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (bitcnt == 4'd0 && state == S_DEV));
endmodule

// File: rtl/dcr_i2c_target.sv
module dcr_i2c_target #(
  parameter int         NREGS         = 4,
  parameter logic [7:0] STAT_ADDR     = 8'h08,
  parameter int         COMMIT_CYCLES = 5_000_000,
  parameter int         SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] strap_i,
  output logic       sda_oe_o
);
  logic       scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] rd_addr, rd_data, wr_addr, wr_data;
  logic       wr_en, commit_start, busy;

  dcr_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_q     (scl_q),
    .sda_q     (sda_q),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  dcr_i2c_engine u_engine (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_q        (scl_q),
    .sda_q        (sda_q),
    .scl_rise     (scl_rise),
    .scl_fall     (scl_fall),
    .start_det    (start_det),
    .stop_det     (stop_det),
    .strap        (strap_i),
    .busy         (busy),
    .rd_data      (rd_data),
    .rd_addr      (rd_addr),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .commit_start (commit_start),
    .sda_oe       (sda_oe_o)
  );

  dcr_regfile #(
    .NREGS         (NREGS),
    .STAT_ADDR     (STAT_ADDR),
    .COMMIT_CYCLES (COMMIT_CYCLES)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .rd_addr      (rd_addr),
    .rd_data      (rd_data),
    .commit_start (commit_start),
    .busy         (busy)
  );
endmodule

// File: tb/dcr_i2c_target_tb.sv
`timescale 1ns/1ps
module dcr_i2c_target_tb;
  localparam int         COMMIT = 3000;
  localparam int         Q      = 8;
  localparam logic [7:0] STAT   = 8'h08;
  localparam logic [7:0] SEL_W  = 8'h54;  // 01010 + strap 10 + W
  localparam logic [7:0] SEL_R  = 8'h55;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe;
  logic [1:0] strap = 2'b10;
  wire  sda_line = ~(sda_oe | m_low);

  int   n_chk = 0, n_fail = 0, mon_fail = 0;
  longint cyc = 0, stop_cyc = -100000;
  bit   exp_release = 1'b0;
  bit   done = 1'b0;
  logic [7:0] got [$];
  logic [7:0] model [4];

  always #2 clk = ~clk;

  dcr_i2c_target #(.NREGS(4), .STAT_ADDR(STAT), .COMMIT_CYCLES(COMMIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .strap_i(strap), .sda_oe_o(sda_oe));

  // Per-clock comparison: wherever the model says the target must be silent.
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && exp_release && sda_oe) mon_fail <= mon_fail + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start;
    m_low = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_low = 1'b1; wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop;
    m_low = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); m_low = 1'b0; wq(Q);
    stop_cyc = cyc;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_low = ~b[i]; wq(Q); m_scl = 1'b1; wq(Q); m_scl = 1'b0; wq(Q);
    end
  endtask

  task automatic write_byte(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    m_low = 1'b0; wq(Q); m_scl = 1'b1; wq(Q/2);
    acked = (sda_line == 1'b0);
    wq(Q/2); m_scl = 1'b0; wq(Q);
  endtask

  task automatic read_byte(input bit give_ack, output logic [7:0] b);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      m_scl = 1'b1; wq(Q/2); b[i] = sda_line; wq(Q/2); m_scl = 1'b0; wq(Q);
    end
    m_low = give_ack; wq(Q); m_scl = 1'b1; wq(Q); m_scl = 1'b0; wq(Q); m_low = 1'b0;
  endtask

  task automatic wr_txn(input logic [7:0] a, input logic [7:0] d, input bit do_stop,
                        output bit k0, output bit k1, output bit k2);
    bus_start; write_byte(SEL_W, k0); write_byte(a, k1); write_byte(d, k2);
    if (do_stop) bus_stop;
  endtask

  task automatic rd_txn(input logic [7:0] a, input int n, output bit ok);
    bit k0, k1, k2;
    logic [7:0] b;
    got.delete();
    bus_start; write_byte(SEL_W, k0); write_byte(a, k1);
    bus_start; write_byte(SEL_R, k2);
    for (int i = 0; i < n; i++) begin
      read_byte(i < n - 1, b);
      got.push_back(b);
    end
    exp_release = 1'b1;
    wq(Q);
    bus_stop;
    exp_release = 1'b0;
    ok = k0 & k1 & k2;
  endtask

  task automatic wait_commit;
    while (cyc - stop_cyc <= COMMIT + 100) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bit k0, k1, k2, ok;
    for (int i = 0; i < 4; i++) model[i] = 8'h00;
    wq(5); rst_n = 1'b1; wq(5);

    // R11: reset state
    chk("R11 sda released", sda_oe, 1'b0);
    rd_txn(8'h00, 4, ok);
    chk("R11 R6 read acks", ok, 1'b1);
    for (int i = 0; i < 4; i++) chk("R11 regs zero", got[i], 8'h00);

    // R2: plain write with STOP
    wr_txn(8'h01, 8'hA5, 1'b1, k0, k1, k2);
    model[1] = 8'hA5;
    chk("R2 ack select", k0, 1'b1);
    chk("R2 ack address", k1, 1'b1);
    chk("R2 ack data", k2, 1'b1);
    // R3 R5: flag rose at STOP
    rd_txn(STAT, 1, ok);
    chk("R3 R5 status busy", got[0], 8'h20);

    // R9: write while busy is refused
    wr_txn(8'h02, 8'h3C, 1'b1, k0, k1, k2);
    chk("R9 select still acked", k0 & k1, 1'b1);
    chk("R9 data nacked", k2, 1'b0);
    rd_txn(8'h02, 1, ok);
    chk("R9 register unchanged", got[0], model[2]);

    // R4: flag clears after the commit window
    wait_commit;
    rd_txn(STAT, 1, ok);
    chk("R4 status idle", got[0], 8'h00);

    // R3: repeated START after the data byte does not start the commit
    wr_txn(8'h00, 8'h11, 1'b0, k0, k1, k2);
    model[0] = 8'h11;
    chk("R3 data acked", k2, 1'b1);
    rd_txn(STAT, 1, ok);
    chk("R3 no commit before STOP", got[0], 8'h00);
    rd_txn(STAT, 1, ok);
    chk("R3 commit after STOP", got[0], 8'h20);
    wait_commit;

    // R5: write to status register has no effect
    wr_txn(STAT, 8'hFF, 1'b1, k0, k1, k2);
    wait_commit;
    rd_txn(STAT, 1, ok);
    chk("R5 status not writable", got[0], 8'h00);

    wr_txn(8'h02, 8'h3C, 1'b1, k0, k1, k2); model[2] = 8'h3C; wait_commit;
    wr_txn(8'h03, 8'hC3, 1'b1, k0, k1, k2); model[3] = 8'hC3; wait_commit;
    chk("R2 write acked", k0 & k1 & k2, 1'b1);

    // R7 R8: sequential read crossing the end of the file and the status slot
    rd_txn(8'h00, 10, ok);
    chk("R6 acks", ok, 1'b1);
    for (int i = 0; i < 10; i++)
      chk("R7 R8 sequential byte", got[i], (i < 4) ? model[i] : 8'h00);
    chk("R8 released after nack", sda_oe, 1'b0);

    // R1: wrong strap and wrong prefix are not answered
    exp_release = 1'b1;
    bus_start; write_byte(8'h52, k0); write_byte(8'h01, k1); bus_stop;
    chk("R1 wrong strap nack", k0 | k1, 1'b0);
    bus_start; write_byte(8'hD4, k0); bus_stop;
    chk("R1 wrong prefix nack", k0, 1'b0);
    exp_release = 1'b0;

    // R10: STOP and START in mid byte
    bus_start; send_bits(SEL_W, 4); bus_stop;
    bus_start; send_bits(SEL_W, 3);
    bus_start; write_byte(SEL_W, k0); write_byte(8'h01, k1);
    bus_start; write_byte(SEL_R, k2);
    read_byte(1'b0, got[0]);
    exp_release = 1'b1; wq(Q); bus_stop; exp_release = 1'b0;
    chk("R10 reframed acks", k0 & k1 & k2, 1'b1);
    chk("R10 reframed data", got[0], model[1]);

    chk("R1 R8 silent windows", mon_fail, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule